// File: doc/BRIEF.md
# LIN Sync-Field Autobaud Unit

This block sits between a LIN break detector and a UART's baud rate generator. A break-done pulse arms it. It then times the sync byte (0x55) that follows on the serial line and works out the sender's real bit period. From that period it derives a 16x-oversampling divisor. It keeps the receiver disabled for the whole measurement. The new divisor is presented with a one-cycle load strobe while the receiver is still off, and the receiver enable rises again on the next cycle so the identifier field can be received.

Timing starts at the falling edge of the start bit. It stops at the fifth falling edge counted from that one, which lies 8 bit times later. The divisor is the span in clocks divided by 128, rounded to nearest. A result of zero is refused. If a gap between line edges runs too long, the measurement is aborted. Both failures raise an error pulse, keep the previous divisor and re-enable the receiver.

Top module: `lin_sync_autobaud`

## Requirements
- R1: After reset, `rx_en` is 1, `div_ld` and `meas_err` are 0, and `div_o` equals the `DIV_RESET` parameter.
- R2: In the idle state, line activity without a `brk_done` pulse starts no measurement: `rx_en` stays 1, no load strobe is produced and `div_o` is unchanged.
- R3: A `brk_done` pulse taken while `rx_en` is 1 drives `rx_en` to 0 on the next cycle. `rx_en` stays 0 until the measurement ends in a load or an error.
- R4: The loaded divisor equals (S + 64) >> 7, where S is the number of clocks between the start-bit falling edge and the fifth falling edge counted from it. For a 0x55 byte sent LSB first with bit period P, S = 8P.
- R5: `div_ld` is a single-cycle pulse, one per successful measurement. During that cycle `div_o` already carries the new nonzero value and `rx_en` is 0.
- R6: `rx_en` returns to 1 in the cycle after `div_ld`.
- R7: If the computed divisor is zero, there is no load strobe and `div_o` keeps its value. `meas_err` pulses for one cycle and `rx_en` returns to 1.
- R8: If no line edge (rising or falling) arrives for `TIMEOUT` consecutive clocks during a measurement, the measurement is aborted. `meas_err` pulses, no load happens and `rx_en` returns to 1.
- R9: A `brk_done` pulse that arrives while a measurement is running is ignored and does not change the result.
- R10: `div_o` changes only in a cycle in which `div_ld` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| brk_done | input | 1 | One-cycle pulse when a valid break has been received |
| rx_i | input | 1 | Serial receive line, asynchronous, idles high |
| div_o | output | DIV_W | Current baud divisor (DIV_W = CNT_W + 1 - log2(SPAN_BITS*OSR)) |
| div_ld | output | 1 | One-cycle strobe to write `div_o` into the baud generator |
| rx_en | output | 1 | Receiver enable, low during measurement and load |
| meas_err | output | 1 | One-cycle pulse when a measurement is refused or times out |

## Verification
The assertions assume that `brk_done` is a clean single-cycle pulse. They also assume that the line carries a 0x55 pattern whose bit period is at least as long as the synchronizer depth and well below `TIMEOUT`. Under those conditions every measured span fits the capture counter. The stimulus drives `rx_i` only on falling clock edges, with bit periods from 4 to 199 clocks against a timeout of 1000. A new frame starts only after the unit has gone back to idle. The deliberate stalls, stray breaks and unarmed frames stay within the same limits on edge spacing.

// File: rtl/lin_ab_pkg.sv
package lin_ab_pkg;

   typedef enum logic [2:0] {
      AB_IDLE,
      AB_WAIT_START,
      AB_MEASURE,
      AB_CALC,
      AB_LOAD
   } ab_state_t;

endpackage

// File: rtl/lin_ab_rxsync.sv
// Metastability synchronizer for the serial line plus edge detection.
module lin_ab_rxsync #(
   parameter int STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic rx_i,
   output logic fall,
   output logic toggle
);

   if (STAGES < 2) begin : g_bad_stages
      $error("lin_ab_rxsync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic              prev_q;
   logic              rx_s;

   assign rx_s = sh_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '1;
         prev_q <= 1'b1;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], rx_i};
         prev_q <= rx_s;
      end
   end

   assign fall   = prev_q & ~rx_s;
   assign toggle = prev_q ^ rx_s;

endmodule

// File: rtl/lin_ab_span.sv
// Span counter, falling-edge counter and inter-edge watchdog.
module lin_ab_span #(
   parameter int CNT_W   = 20,
   parameter int NFALL   = 5,
   parameter int TIMEOUT = 65535,
   localparam int FC_W   = (NFALL > 2) ? $clog2(NFALL) : 1,
   localparam int WD_W   = $clog2(TIMEOUT + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic             wd_run,
   input  logic             fall,
   input  logic             toggle,
   output logic             last,
   output logic             wd_exp,
   output logic [CNT_W-1:0] span_cap
);

   logic [CNT_W-1:0] span_q;
   logic [FC_W-1:0]  fcnt_q;
   logic [WD_W-1:0]  wd_q;

   assign last   = run & fall & (fcnt_q == FC_W'(NFALL - 2));
   assign wd_exp = wd_run & ~toggle & (wd_q == WD_W'(TIMEOUT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         span_q   <= '0;
         fcnt_q   <= '0;
         span_cap <= '0;
      end else begin
         if (clr) begin
            span_q <= '0;
            fcnt_q <= '0;
         end else if (run) begin
            span_q <= span_q + 1'b1;
            if (fall) fcnt_q <= fcnt_q + 1'b1;
         end
         if (last) span_cap <= span_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                wd_q <= '0;
      else if (!wd_run || toggle) wd_q <= '0;
      else                       wd_q <= wd_q + 1'b1;
   end

   // R8: the inter-edge watchdog never runs past its limit
   a_r8_wd_bound: assert property (@(posedge clk) disable iff (!rst_n)
      wd_run |-> (32'(wd_q) < TIMEOUT));

   // R4: the capture completes before the falling-edge count overruns
   a_r4_fall_count: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (32'(fcnt_q) <= NFALL - 2));

endmodule

// File: rtl/lin_ab_divcalc.sv
// Span-to-divisor conversion; rounding variant chosen by parameter.
module lin_ab_divcalc #(
   parameter int CNT_W         = 20,
   parameter int SHIFT         = 7,
   parameter bit ROUND_NEAREST = 1'b1,
   localparam int DIV_W        = CNT_W + 1 - SHIFT
)(
   input  logic [CNT_W-1:0] span,
   output logic [DIV_W-1:0] quo,
   output logic             zero
);

   if (SHIFT < 1 || SHIFT >= CNT_W) begin : g_bad_shift
      $error("lin_ab_divcalc: SHIFT must lie in 1..CNT_W-1");
   end

   if (ROUND_NEAREST) begin : g_nearest
      localparam logic [CNT_W:0] HALF = {{CNT_W{1'b0}}, 1'b1} << (SHIFT - 1);
      logic [CNT_W:0] sum;
      assign sum = {1'b0, span} + HALF;
      assign quo = DIV_W'(sum >> SHIFT);
   end else begin : g_truncate
      assign quo = DIV_W'(span >> SHIFT);
   end

   assign zero = (quo == '0);

endmodule

// File: rtl/lin_sync_autobaud.sv
module lin_sync_autobaud
   import lin_ab_pkg::*;
#(
   parameter int CNT_W         = 20,
   parameter int SPAN_BITS     = 8,
   parameter int OSR           = 16,
   parameter int TIMEOUT       = 65535,
   parameter int SYNC_STAGES   = 2,
   parameter bit ROUND_NEAREST = 1'b1,
   parameter int DIV_RESET     = 1,
   localparam int SHIFT        = $clog2(SPAN_BITS * OSR),
   localparam int DIV_W        = CNT_W + 1 - SHIFT
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             brk_done,
   input  logic             rx_i,
   output logic [DIV_W-1:0] div_o,
   output logic             div_ld,
   output logic             rx_en,
   output logic             meas_err
);

   localparam int NFALL = SPAN_BITS / 2 + 1;

   if (SPAN_BITS < 2 || (1 << $clog2(SPAN_BITS)) != SPAN_BITS) begin : g_bad_span
      $error("lin_sync_autobaud: SPAN_BITS must be an even power of two");
   end
   if ((1 << $clog2(OSR)) != OSR) begin : g_bad_osr
      $error("lin_sync_autobaud: OSR must be a power of two");
   end
   if (CNT_W > 30 || (longint'(1) << CNT_W) <= longint'(SPAN_BITS) * TIMEOUT) begin : g_bad_cnt
      $error("lin_sync_autobaud: CNT_W too small for SPAN_BITS*TIMEOUT");
   end

   ab_state_t        state_q;
   logic [DIV_W-1:0] div_q;
   logic             err_q;

   logic             rx_fall, rx_tog;
   logic             span_clr, span_run, wd_run, span_last, wd_exp;
   logic [CNT_W-1:0] span_cap;
   logic [DIV_W-1:0] quo;
   logic             quo_zero;

   lin_ab_rxsync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .rx_i   (rx_i),
      .fall   (rx_fall),
      .toggle (rx_tog)
   );

   assign span_clr = (state_q == AB_WAIT_START) & rx_fall;
   assign span_run = (state_q == AB_MEASURE);
   assign wd_run   = (state_q == AB_WAIT_START) | (state_q == AB_MEASURE);

   lin_ab_span #(.CNT_W(CNT_W), .NFALL(NFALL), .TIMEOUT(TIMEOUT)) u_span (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (span_clr),
      .run      (span_run),
      .wd_run   (wd_run),
      .fall     (rx_fall),
      .toggle   (rx_tog),
      .last     (span_last),
      .wd_exp   (wd_exp),
      .span_cap (span_cap)
   );

   lin_ab_divcalc #(.CNT_W(CNT_W), .SHIFT(SHIFT), .ROUND_NEAREST(ROUND_NEAREST)) u_div (
      .span (span_cap),
      .quo  (quo),
      .zero (quo_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= AB_IDLE;
         div_q   <= DIV_W'(DIV_RESET);
         err_q   <= 1'b0;
      end else begin
         err_q <= 1'b0;
         case (state_q)
            AB_IDLE:
               if (brk_done) state_q <= AB_WAIT_START;
            AB_WAIT_START:
               if (rx_fall) state_q <= AB_MEASURE;
               else if (wd_exp) begin
                  state_q <= AB_IDLE;
                  err_q   <= 1'b1;
               end
            AB_MEASURE:
               if (span_last) state_q <= AB_CALC;
               else if (wd_exp) begin
                  state_q <= AB_IDLE;
                  err_q   <= 1'b1;
               end
            AB_CALC:
               if (quo_zero) begin
                  state_q <= AB_IDLE;
                  err_q   <= 1'b1;
               end else begin
                  div_q   <= quo;
                  state_q <= AB_LOAD;
               end
            AB_LOAD:
               state_q <= AB_IDLE;
            default:
               state_q <= AB_IDLE;
         endcase
      end
   end

   assign div_o    = div_q;
   assign div_ld   = (state_q == AB_LOAD);
   assign rx_en    = (state_q == AB_IDLE);
   assign meas_err = err_q;

   // R3: an accepted break disables the receiver on the next cycle
   a_r3_break_disables: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && brk_done) |=> !rx_en);

   // R5: the load happens only with the receiver off and a nonzero divisor
   a_r5_load_while_off: assert property (@(posedge clk) disable iff (!rst_n)
      div_ld |-> (!rx_en && (div_o != '0)));

   // R6: the receiver comes back one cycle after a single-cycle strobe
   a_r6_reenable: assert property (@(posedge clk) disable iff (!rst_n)
      div_ld |=> (rx_en && !div_ld));

   // R7: an error never coincides with a load and leaves the receiver on
   a_r7_err_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      meas_err |-> (!div_ld && rx_en));

   // R10: the divisor only moves together with the load strobe
   a_r10_div_moves_on_ld: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_o) |-> div_ld);

endmodule

// File: tb/sim_lin_sync_autobaud.sv
module sim_lin_sync_autobaud;

   localparam int CNT_W = 14;
   localparam int TMO   = 1000;
   localparam int DIVR  = 5;
   localparam int DW    = CNT_W + 1 - 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          brk = 1'b0;
   logic          rx = 1'b1;
   logic [DW-1:0] div_o;
   logic          div_ld, rx_en, meas_err;

   always #4 clk = ~clk;

   lin_sync_autobaud #(
      .CNT_W(CNT_W), .SPAN_BITS(8), .OSR(16), .TIMEOUT(TMO),
      .SYNC_STAGES(2), .ROUND_NEAREST(1'b1), .DIV_RESET(DIVR)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .brk_done(brk), .rx_i(rx),
      .div_o(div_o), .div_ld(div_ld), .rx_en(rx_en), .meas_err(meas_err)
   );

   int n_chk = 0;
   int n_err = 0;
   int exp_div = DIVR;

   int   ld_cnt = 0;
   int   err_cnt = 0;
   int   ld_div = 0;
   logic ld_rxen = 1'b1;
   logic after_rxen = 1'b0;
   logic prev_ld = 1'b0;

   always @(negedge clk) begin
      if (div_ld) begin
         ld_cnt  = ld_cnt + 1;
         ld_div  = int'(div_o);
         ld_rxen = rx_en;
      end
      if (prev_ld) after_rxen = rx_en;
      prev_ld = div_ld;
      if (meas_err) err_cnt = err_cnt + 1;
   end

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_brk;
      @(negedge clk) brk = 1'b1;
      @(negedge clk) brk = 1'b0;
   endtask

   // 0x55 sent LSB first: start 0, data 1,0,1,0,1,0,1,0, stop 1
   task automatic send_sync(input int p, input bit arm, input bit stray, input int nbits);
      if (arm) begin
         pulse_brk();
         check("R3 rx_en low after break", int'(rx_en), 0);
         check("R10 divisor held during measurement", int'(div_o), exp_div);
      end
      hold(3);
      for (int b = 0; b < nbits; b++) begin
         bit v;
         if (b == 0)      v = 1'b0;
         else if (b == 9) v = 1'b1;
         else             v = ((b - 1) % 2 == 0);
         rx = v;
         for (int j = 0; j < p; j++) begin
            brk = (stray && b == 4 && j == 1);
            @(negedge clk);
         end
      end
      brk = 1'b0;
      rx  = 1'b1;
   endtask

   task automatic run_frame(input int p);
      int s_ld, s_err, e;
      s_ld  = ld_cnt;
      s_err = err_cnt;
      send_sync(p, 1'b1, 1'b0, 10);
      hold(12);
      e = (8 * p + 64) >> 7;
      if (e == 0) begin
         check("R7 zero divisor not loaded", ld_cnt - s_ld, 0);
         check("R7 zero divisor flags error", err_cnt - s_err, 1);
         check("R7 divisor kept", int'(div_o), exp_div);
         check("R7 receiver re-enabled", int'(rx_en), 1);
      end else begin
         check("R5 one load strobe", ld_cnt - s_ld, 1);
         check("R4 loaded divisor", ld_div, e);
         check("R5 receiver off at load", int'(ld_rxen), 0);
         check("R6 receiver on after load", int'(after_rxen), 1);
         check("R10 divisor output", int'(div_o), e);
         check("R4 no error on good frame", err_cnt - s_err, 0);
         exp_div = e;
      end
   endtask

   initial begin
      hold(5);
      rst_n = 1'b1;
      hold(2);
      check("R1 rx_en after reset", int'(rx_en), 1);
      check("R1 div_ld after reset", int'(div_ld), 0);
      check("R1 meas_err after reset", int'(meas_err), 0);
      check("R1 divisor after reset", int'(div_o), DIVR);

      // R2: a sync pattern without a break is not measured
      begin
         int s_ld, s_err;
         s_ld = ld_cnt; s_err = err_cnt;
         send_sync(40, 1'b0, 1'b0, 10);
         hold(20);
         check("R2 no load without break", ld_cnt - s_ld, 0);
         check("R2 no error without break", err_cnt - s_err, 0);
         check("R2 receiver stays on", int'(rx_en), 1);
         check("R2 divisor unchanged", int'(div_o), exp_div);
      end

      // R4 R5 R6 R7: sweep of bit periods, including zero-divisor cases
      for (int p = 4; p < 200; p += 3) run_frame(p);

      // R9: a stray break during the measurement changes nothing
      begin
         int s_ld;
         s_ld = ld_cnt;
         send_sync(40, 1'b1, 1'b1, 10);
         hold(12);
         check("R9 single load despite stray break", ld_cnt - s_ld, 1);
         check("R9 divisor unaffected", ld_div, 3);
         exp_div = 3;
      end

      // R8: no start bit at all
      begin
         int s_ld, s_err;
         s_ld = ld_cnt; s_err = err_cnt;
         pulse_brk();
         hold(TMO - 10);
         check("R8 no early timeout", err_cnt - s_err, 0);
         check("R8 receiver still off", int'(rx_en), 0);
         hold(20);
         check("R8 timeout error", err_cnt - s_err, 1);
         check("R8 receiver back on", int'(rx_en), 1);
         check("R8 no load on timeout", ld_cnt - s_ld, 0);
         check("R8 divisor kept", int'(div_o), exp_div);
      end

      // R8: line stalls partway through the sync byte
      begin
         int s_ld, s_err;
         s_ld = ld_cnt; s_err = err_cnt;
         send_sync(20, 1'b1, 1'b0, 4);
         hold(TMO + 20);
         check("R8 stall error", err_cnt - s_err, 1);
         check("R8 stall no load", ld_cnt - s_ld, 0);
         check("R8 stall receiver on", int'(rx_en), 1);
      end

      // R4: a good frame still works after the aborts
      run_frame(64);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #(8 * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule